// File: doc/BRIEF.md
# Board Control Register Block

This block is a slave register file on a plain 32-bit read/write bus. It holds the board's small control state: an eight-lamp LED bar, an eight-character text display buffer, a break/reset byte, a general-purpose output byte and a set of bit-banged I2C pin registers. It also provides a software reset trigger. Only the low 20 address bits select a register, so the block can sit in any 1 MB window.

The text buffer can be loaded in two ways. A word write turns a 32-bit value into eight uppercase hexadecimal ASCII characters. A character write sets a single position. Every display load raises a one-cycle update strobe so that a renderer downstream knows to redraw. Writing a key value to the reset register raises a one-cycle reset request.

The I2C output register drives the SCL and SDA lines toward an external serial EEPROM. The live SDA level that comes back from the EEPROM is visible in the I2C input register. Reads are combinational from the address. Writes take effect at the clock edge where `bus_wr` is high.

Top module: `board_ctl_regs`

## Requirements
- R1: Only `bus_addr[19:0]` is decoded. A read of any offset without a register returns 0. A write to such an offset changes no state and raises no pulse.
- R2: Offset 0x200 (switches) and offset 0x210 (jumpers) both read 0, and writes to them are ignored. Offset 0x208 (status) reads 0x12 when `BIG_ENDIAN`=1 and 0x10 when `BIG_ENDIAN`=0.
- R3: The LED register at 0x408 stores `wdata[7:0]`, drives it on `led_out` and reads it back. Its reset value is 0x00.
- R4: A write to 0x410 loads display positions 0..7 with the uppercase hex ASCII of the value's nibbles. Position 0 takes bits 31:28 and position 7 takes bits 3:0. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46. Position p appears on `disp_chars[8p+7:8p]`.
- R5: A write to offset 0x418+8p (p = 0..7) sets position p to `wdata[7:0]`. An offset in 0x418..0x450 that is not a multiple of 8 is ignored, and so is 0x458. At reset every position holds 0x20.
- R6: `disp_update` is high for exactly the one cycle after each accepted display write (word or character).
- R7: A write of exactly 0x00000042 to 0x500 makes `sys_reset_req` high for one cycle, the cycle after the write. Any other value written there does nothing.
- R8: The break register at 0x508 (reset 0x0A) and the general output register at 0xA00 (reset 0x00) each store `wdata[7:0]` and read it back. They drive `brk_out` and `gpo_out`.
- R9: The output-enable register at 0xB08 keeps `wdata[1:0]` (reset 0) and drives `i2c_oe`. The select register at 0xB18 keeps `wdata[0]` (reset 1).
- R10: The I2C output register at 0xB10 stores the full 32-bit write (reset 0x3) and reads it back. `scl_out` is bit 1 of the stored value and `sda_out` is bit 0.
- R11: A read of 0xB00 returns 0x2 with bit 0 replaced by the live `sda_in` level.
- R12: A read of 0xA08 returns the I2C output register when select is 1, and 0 when select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address; only bits 19:0 are decoded |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| led_out | output | 8 | LED bar |
| disp_chars | output | 64 | Display buffer, position p at bits 8p+7:8p |
| disp_update | output | 1 | One-cycle strobe after a display load |
| sys_reset_req | output | 1 | One-cycle system reset request |
| brk_out | output | 8 | Break/reset byte |
| gpo_out | output | 8 | General-purpose output byte |
| i2c_oe | output | 2 | I2C output-enable bits |
| scl_out | output | 1 | SCL toward the EEPROM |
| sda_out | output | 1 | SDA toward the EEPROM |
| sda_in | input | 1 | SDA level from the EEPROM |

## Verification
The bench builds the block with `BIG_ENDIAN`=0, so only the 0x10 status value is checked against a live read. The 0x12 value needs a second build. Under this default the bench can reach every write path, both display load paths (including the 9-to-A digit boundary and the first and last character positions), the select-dependent read of 0xA08 and the live SDA bit. It also covers the full-address aliasing caused by ignoring the upper 12 bits.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter bit       BIG_ENDIAN = 1'b0,
  parameter int       OFF_W      = 20,
  parameter logic [7:0] RST_KEY  = 8'h42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  led_out,
  output logic [63:0] disp_chars,
  output logic        disp_update,
  output logic        sys_reset_req,
  output logic [7:0]  brk_out,
  output logic [7:0]  gpo_out,
  output logic [1:0]  i2c_oe,
  output logic        scl_out,
  output logic        sda_out,
  input  logic        sda_in
);
  localparam logic [OFF_W-1:0] A_SWITCH = 'h200;
  localparam logic [OFF_W-1:0] A_STATUS = 'h208;
  localparam logic [OFF_W-1:0] A_JUMPER = 'h210;
  localparam logic [OFF_W-1:0] A_LED    = 'h408;
  localparam logic [OFF_W-1:0] A_HEXW   = 'h410;
  localparam logic [OFF_W-1:0] A_CHAR0  = 'h418;
  localparam logic [OFF_W-1:0] A_CHAR7  = 'h450;
  localparam logic [OFF_W-1:0] A_SWRST  = 'h500;
  localparam logic [OFF_W-1:0] A_BRK    = 'h508;
  localparam logic [OFF_W-1:0] A_GPO    = 'h a00;
  localparam logic [OFF_W-1:0] A_GPI    = 'h a08;
  localparam logic [OFF_W-1:0] A_I2CIN  = 'h b00;
  localparam logic [OFF_W-1:0] A_I2COE  = 'h b08;
  localparam logic [OFF_W-1:0] A_I2COUT = 'h b10;
  localparam logic [OFF_W-1:0] A_I2CSEL = 'h b18;
  localparam logic [31:0] STATUS_VAL = BIG_ENDIAN ? 32'h12 : 32'h10;
  localparam logic [31:0] I2CIN_VAL  = 32'h3;

  logic [OFF_W-1:0] off, char_rel;
  logic [7:0]  brk_q;
  logic        sel_q;
  logic [31:0] i2cout_q;
  logic        wr_hex, wr_char, wr_rst;
  logic [2:0]  char_idx;
  logic        unused_hi;

  assign off       = bus_addr[OFF_W-1:0];
  assign unused_hi = ^bus_addr[31:OFF_W];
  assign char_rel  = off - A_CHAR0;
  assign char_idx  = char_rel[5:3];
  assign wr_hex    = bus_wr && off == A_HEXW;
  assign wr_char   = bus_wr && off >= A_CHAR0 && off <= A_CHAR7 && off[2:0] == 3'b000;
  assign wr_rst    = bus_wr && off == A_SWRST && bus_wdata == {24'h0, RST_KEY};

  assign brk_out = brk_q;
  assign scl_out = i2cout_q[1];
  assign sda_out = i2cout_q[0];

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + {4'h0, n} : 8'h37 + {4'h0, n};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_out       <= 8'h00;
      brk_q         <= 8'h0A;
      gpo_out       <= 8'h00;
      i2c_oe        <= 2'b00;
      i2cout_q      <= 32'h3;
      sel_q         <= 1'b1;
      disp_chars    <= {8{8'h20}};
      disp_update   <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      disp_update   <= wr_hex || wr_char;
      sys_reset_req <= wr_rst;
      if (bus_wr) begin
        case (off)
          A_LED:    led_out  <= bus_wdata[7:0];
          A_BRK:    brk_q    <= bus_wdata[7:0];
          A_GPO:    gpo_out  <= bus_wdata[7:0];
          A_I2COE:  i2c_oe   <= bus_wdata[1:0];
          A_I2COUT: i2cout_q <= bus_wdata;
          A_I2CSEL: sel_q    <= bus_wdata[0];
          default: ;
        endcase
      end
      if (wr_hex)
        for (int p = 0; p < 8; p++)
          disp_chars[8*p +: 8] <= hex_ascii(bus_wdata[28-4*p +: 4]);
      if (wr_char)
        disp_chars[8*char_idx +: 8] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    case (off)
      A_SWITCH: bus_rdata = 32'h0;
      A_STATUS: bus_rdata = STATUS_VAL;
      A_JUMPER: bus_rdata = 32'h0;
      A_LED:    bus_rdata = {24'h0, led_out};
      A_BRK:    bus_rdata = {24'h0, brk_q};
      A_GPO:    bus_rdata = {24'h0, gpo_out};
      A_GPI:    bus_rdata = sel_q ? i2cout_q : 32'h0;
      A_I2CIN:  bus_rdata = {I2CIN_VAL[31:1], sda_in};
      A_I2COE:  bus_rdata = {30'h0, i2c_oe};
      A_I2COUT: bus_rdata = i2cout_q;
      A_I2CSEL: bus_rdata = {31'h0, sel_q};
      default:  bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [7:0]  led_out,
  input logic        disp_update,
  input logic        sys_reset_req,
  input logic        scl_out,
  input logic        sda_out,
  input logic        sda_in
);
  logic [19:0] off;
  assign off = bus_addr[19:0];

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (off == 20'h300 || off == 20'h41C || off == 20'h458) |-> bus_rdata == 32'h0); // R1

  AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == 20'h408) |=> led_out == $past(bus_wdata[7:0])); // R3

  AST_DISP_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    disp_update |-> $past(bus_wr && off >= 20'h410 && off <= 20'h450 && off[2:0] == 3'b000)); // R6

  AST_RESET_REQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(bus_wr && off == 20'h500 && bus_wdata == 32'h42)); // R7

  AST_I2C_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && off == 20'hB10) |=> (scl_out == $past(bus_wdata[1]) && sda_out == $past(bus_wdata[0]))); // R10

  AST_SDA_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    off == 20'hB00 |-> bus_rdata == {30'h0, 1'b1, sda_in}); // R11
endmodule

bind board_ctl_regs board_ctl_regs_chk chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .led_out(led_out),
  .disp_update(disp_update), .sys_reset_req(sys_reset_req),
  .scl_out(scl_out), .sda_out(sda_out), .sda_in(sda_in)
);

// File: tb/board_ctl_regs_test.sv
module board_ctl_regs_test;
  localparam bit BE = 1'b0;
  logic clk = 0, rst_n = 0, bus_wr = 0, sda_in = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [7:0] led_out, brk_out, gpo_out;
  logic [63:0] disp_chars;
  logic disp_update, sys_reset_req, scl_out, sda_out;
  logic [1:0] i2c_oe;
  int n_run = 0, n_fail = 0;
  logic upd_seen, rst_seen;

  board_ctl_regs #(.BIG_ENDIAN(BE)) uut (.*);

  always #2 clk = ~clk;

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 32'h300;
    upd_seen = disp_update; rst_seen = sys_reset_req;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R3 led reset", led_out, 0);
    chk("R8 brk reset", brk_out, 8'h0A);
    chk("R8 gpo reset", gpo_out, 0);
    chk("R5 disp reset", disp_chars, {8{8'h20}});
    chk("R9 oe reset", i2c_oe, 0);
    chk("R10 pins reset", {scl_out, sda_out}, 2'b11);
    rd(32'hB18, d); chk("R9 sel reset", d, 1);
    rd(32'hA08, d); chk("R12 gpi sel1", d, 3);
    chk("R6/R7 idle pulses", {disp_update, sys_reset_req}, 0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    rd(32'h200, d); chk("R2 switch", d, 0);
    rd(32'h208, d); chk("R2 status", d, BE ? 32'h12 : 32'h10);
    wr(32'h210, 32'hFFFF_FFFF); rd(32'h210, d); chk("R2 jumper write ignored", d, 0);
    wr(32'h200, 32'h55); rd(32'h200, d); chk("R2 switch write ignored", d, 0);
    wr(32'h600, 32'hFF); rd(32'h600, d); chk("R1 unmapped read", d, 0);
    chk("R1 unmapped write no effect", {led_out, brk_out, gpo_out, upd_seen, rst_seen}, {8'h0, 8'h0A, 8'h0, 2'b00});
  endtask

  task automatic t_byte_regs;
    logic [31:0] d;
    wr(32'h408, 32'h1234_56A5); chk("R3 led out", led_out, 8'hA5);
    rd(32'h408, d); chk("R3 led read", d, 32'hA5);
    wr(32'hFFF0_0408, 32'h3C); chk("R1 alias upper bits", led_out, 8'h3C);
    wr(32'h508, 32'hFFFF_FF77); rd(32'h508, d); chk("R8 brk", {d, 24'h0, brk_out}, {32'h77, 32'h77});
    wr(32'hA00, 32'h0000_01C3); rd(32'hA00, d); chk("R8 gpo", {d, 24'h0, gpo_out}, {32'hC3, 32'hC3});
  endtask

  task automatic t_display;
    wr(32'h410, 32'hDEAD_BEEF);
    chk("R4 hex word letters", disp_chars, 64'h4645_4542_4441_4544);
    chk("R6 strobe word", upd_seen, 1);
    @(negedge clk); chk("R6 strobe one cycle", disp_update, 0);
    wr(32'h410, 32'h09A0_F5C3);
    chk("R4 hex word digits", disp_chars, 64'h3343_3546_3041_3930);
    wr(32'h418, 32'h1234_5661); chk("R5 char pos0", disp_chars[7:0], 8'h61);
    chk("R6 strobe char", upd_seen, 1);
    wr(32'h450, 32'h7A); chk("R5 char pos7", disp_chars[63:56], 8'h7A);
    wr(32'h430, 32'h2B); chk("R5 char pos3", disp_chars, 64'h7A43_3546_2B41_3961);
    wr(32'h41C, 32'h21); chk("R5 misaligned ignored", {disp_chars, 7'h0, upd_seen}, {64'h7A43_3546_2B41_3961, 8'h0});
    wr(32'h458, 32'h21); chk("R5 past end ignored", {disp_chars, 7'h0, upd_seen}, {64'h7A43_3546_2B41_3961, 8'h0});
  endtask

  task automatic t_swreset;
    wr(32'h500, 32'h43); chk("R7 wrong key", rst_seen, 0);
    wr(32'h500, 32'h142); chk("R7 key upper bits", rst_seen, 0);
    wr(32'h504, 32'h42); chk("R7 wrong offset", rst_seen, 0);
    wr(32'h500, 32'h42); chk("R7 key pulse", rst_seen, 1);
    @(negedge clk); chk("R7 one cycle", sys_reset_req, 0);
  endtask

  task automatic t_i2c;
    logic [31:0] d;
    wr(32'hB08, 32'hFFFF_FFFE); chk("R9 oe", i2c_oe, 2'b10);
    rd(32'hB08, d); chk("R9 oe read", d, 2);
    wr(32'hB10, 32'hABCD_0002); chk("R10 scl1 sda0", {scl_out, sda_out}, 2'b10);
    rd(32'hB10, d); chk("R10 full readback", d, 32'hABCD_0002);
    wr(32'hB10, 32'h1); chk("R10 scl0 sda1", {scl_out, sda_out}, 2'b01);
    rd(32'hA08, d); chk("R12 gpi follows out", d, 1);
    sda_in = 0; rd(32'hB00, d); chk("R11 sda low", d, 2);
    sda_in = 1; rd(32'hB00, d); chk("R11 sda high", d, 3);
    wr(32'hB18, 32'hFFFF_FFFE); rd(32'hB18, d); chk("R9 sel keeps bit0", d, 0);
    rd(32'hA08, d); chk("R12 gpi sel0", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_byte_regs();
    t_display();
    t_swreset();
    t_i2c();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule